// File: doc/BRIEF.md
# Write-Masked Sampling Random Bit Collector

This block is a memory-mapped random-number controller with a 32-bit register bus. Software sets up three things through a control register and a period register: the sampling period, how many bits to gather, and an oscillator speed code. The control register takes a per-bit write mask in the upper half of each written word, so software can change one field without first reading the register back.

Software then sets the start bit. From then on the block takes one bit from an entropy source each time the sampling period elapses, until the selected length is full. When the last bit is in, the start bit clears itself, so the same bit serves as the busy and done flag that software polls. The result is read from a run of consecutive 32-bit data words. A free-running linear feedback shift register takes the place of the physical oscillator. It delivers one bit per clock, qualified by a valid strobe.

Top module: `trng_sampler`

## Requirements
- R1: A write to offset 0x400 changes control bit i (i = 0..15) only where bit i+16 of the written word is 1. Masked-off bits keep their value. Bits [15:1] read back as they were written: bit 1 is ENABLE, bits [3:2] are the speed code, bits [5:4] are the length code, and the other bits have no function. Bit 0 reads as START.
- R2: A masked write of START = 1 whose resulting ENABLE is 0 starts nothing, and START reads 0. Clearing ENABLE while a collection runs stops it.
- R3: A masked write of START = 1 with the resulting ENABLE = 1 clears all data words and sets START to 1. With period P read from offset 0x404 (P = 0 acts as 1), the k-th bit (k = 1, 2, ...) is captured k·P clock edges after the edge that accepted the start write.
- R4: Length code n selects (n+1)·64 bits. START drops to 0 at the clock edge that captures the last bit.
- R5: Captured bit number k (counted from 0) lands in data word k/32 at bit k%32. Data word w is read at offset 0x410 + 4·w, for w = 0..7.
- R6: Data words beyond the selected length read zero after a collection.
- R7: Writing 0xFFFF0000 to 0x400 clears all control bits and ends a running collection at once. The data already gathered is kept.
- R8: The entropy stand-in is a 32-bit Galois shift register. It resets to 0xACE12357, and every clock it shifts right, XOR-ing in 0x80200003 when the bit shifted out is 1. A captured bit is its bit 0 just before the capturing edge.
- R9: A START = 1 write accepted while a collection runs restarts the collection from bit 0. This holds also when the write lands on the edge that would have completed the run.
- R10: Writes to the data words, and to offsets with no register, change nothing. Reads of offsets with no register, or of addresses that are not word-aligned, return zero. Reads return data in the same cycle, with no wait.
- R11: After reset the control register reads 0, the period register reads 1000 and every data word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data (for 0x400: mask in [31:16], value in [15:0]) |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
Two events can fall on the same clock edge: the capture that completes a collection, and a software write to the control register that restarts or stops it. The bench provokes this by placing a start write exactly 64·P edges after the previous start, and by restarting and stopping runs in the middle. Its behavioural model applies the rule that the written value wins over completion. Every clock, it compares the addressed register against the model, so a wrong priority shows up as a START or data-word mismatch.

// File: rtl/trng_pkg.sv
package trng_pkg;
   typedef logic [15:0] ctl_half_t;

   function automatic logic [31:0] lfsr_next(input logic [31:0] cur, input logic [31:0] taps);
      return {1'b0, cur[31:1]} ^ (cur[0] ? taps : 32'h0);
   endfunction
endpackage

// File: rtl/trng_lfsr_src.sv
module trng_lfsr_src #(
   parameter int          W    = 32,
   parameter logic [31:0] SEED = 32'hACE1_2357,
   parameter logic [31:0] TAPS = 32'h8020_0003
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   output logic src_bit,
   output logic src_vld
);
   import trng_pkg::*;

   if (W != 32) begin : g_bad_width
      $error("trng_lfsr_src: only a 32-bit register is supported");
   end

   logic [31:0] lfsr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lfsr_q <= SEED;
      else        lfsr_q <= lfsr_next(lfsr_q, TAPS);
   end

   assign src_bit = lfsr_q[0];
   assign src_vld = enable;
endmodule

// File: rtl/trng_collect.sv
module trng_collect #(
   parameter int PER_W     = 32,
   parameter int LEN_UNIT  = 64,
   parameter int LEN_SEL_W = 2,
   localparam int MAX_BITS = LEN_UNIT << LEN_SEL_W,
   localparam int NB_W     = $clog2(MAX_BITS + 1),
   localparam int IDX_W    = $clog2(MAX_BITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_req,
   input  logic                 stop_req,
   input  logic                 enable,
   input  logic                 src_bit,
   input  logic                 src_vld,
   input  logic [PER_W-1:0]     period,
   input  logic [LEN_SEL_W-1:0] len_sel,
   output logic                 running,
   output logic [MAX_BITS-1:0]  data
);
   logic [PER_W-1:0]    cnt_q;
   logic [NB_W-1:0]     nb_q;
   logic [NB_W-1:0]     len_bits;
   logic [PER_W-1:0]    eff_per;
   logic                tick;
   logic                last;
   logic                capture;

   assign len_bits = NB_W'((int'(len_sel) + 1) * LEN_UNIT);
   assign eff_per  = (period == '0) ? PER_W'(1) : period;
   assign tick     = ({1'b0, cnt_q} + 1'b1) >= {1'b0, eff_per};
   assign last     = (nb_q + 1'b1) >= len_bits;
   assign capture  = running && enable && src_vld && tick && !start_req && !stop_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt_q   <= '0;
         nb_q    <= '0;
         data    <= '0;
      end else if (start_req) begin
         running <= 1'b1;
         cnt_q   <= '0;
         nb_q    <= '0;
         data    <= '0;
      end else if (stop_req) begin
         running <= 1'b0;
      end else if (running && enable && src_vld) begin
         if (tick) begin
            data[nb_q[IDX_W-1:0]] <= src_bit;
            nb_q  <= nb_q + 1'b1;
            cnt_q <= '0;
            if (last) running <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R2: a run never survives without ENABLE
   p_run_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> enable);

   // R9: an accepted start begins from bit zero
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |=> (running && nb_q == '0 && cnt_q == '0));

   // R4: capturing the last bit ends the run
   p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && last) |=> !running);

   // R7: idle data is left alone
   p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !start_req) |=> $stable(data));
endmodule

// File: rtl/trng_sampler.sv
module trng_sampler #(
   parameter int          ADDR_W    = 12,
   parameter int          PER_W     = 32,
   parameter int          DEF_PER   = 1000,
   parameter int          LEN_UNIT  = 64,
   parameter int          LEN_SEL_W = 2,
   parameter int          CTL_OFS   = 'h400,
   parameter int          PER_OFS   = 'h404,
   parameter int          DATA_OFS  = 'h410,
   parameter logic [31:0] SEED      = 32'hACE1_2357,
   parameter logic [31:0] TAPS      = 32'h8020_0003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);
   import trng_pkg::*;

   localparam int MAX_BITS = LEN_UNIT << LEN_SEL_W;
   localparam int WORDS    = MAX_BITS / 32;
   localparam int LEN_LSB  = 4;

   if (LEN_UNIT % 32 != 0) begin : g_bad_unit
      $error("trng_sampler: LEN_UNIT must be a multiple of 32");
   end
   if (LEN_LSB + LEN_SEL_W > 16) begin : g_bad_len
      $error("trng_sampler: length field does not fit the control half");
   end
   if (PER_W > 32) begin : g_bad_per
      $error("trng_sampler: period wider than the bus");
   end

   logic [15:1]         ctl_q;
   logic [PER_W-1:0]    per_q;
   logic                running;
   logic [MAX_BITS-1:0] data;
   logic                src_bit, src_vld;
   ctl_half_t           mask, cur, nxt;
   logic                ctl_wr, per_wr, start_req, stop_req;
   logic [31:0]         words [WORDS];

   assign ctl_wr    = bus_wr && (bus_addr == ADDR_W'(CTL_OFS));
   assign per_wr    = bus_wr && (bus_addr == ADDR_W'(PER_OFS));
   assign mask      = bus_wdata[31:16];
   assign cur       = {ctl_q, running};
   assign nxt       = (cur & ~mask) | (bus_wdata[15:0] & mask);
   assign start_req = ctl_wr && mask[0] && bus_wdata[0] && nxt[1];
   assign stop_req  = ctl_wr && !start_req && (!nxt[1] || (mask[0] && !bus_wdata[0]));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         per_q <= PER_W'(DEF_PER);
      end else begin
         if (ctl_wr) ctl_q <= nxt[15:1];
         if (per_wr) per_q <= bus_wdata[PER_W-1:0];
      end
   end

   trng_lfsr_src #(.W(32), .SEED(SEED), .TAPS(TAPS)) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (ctl_q[1]),
      .src_bit (src_bit),
      .src_vld (src_vld)
   );

   trng_collect #(.PER_W(PER_W), .LEN_UNIT(LEN_UNIT), .LEN_SEL_W(LEN_SEL_W)) u_collect (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .stop_req  (stop_req),
      .enable    (ctl_q[1]),
      .src_bit   (src_bit),
      .src_vld   (src_vld),
      .period    (per_q),
      .len_sel   (ctl_q[LEN_LSB +: LEN_SEL_W]),
      .running   (running),
      .data      (data)
   );

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign words[w] = data[w*32 +: 32];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CTL_OFS)) bus_rdata = {16'h0, ctl_q, running};
      else if (bus_addr == ADDR_W'(PER_OFS)) bus_rdata = 32'(per_q);
      for (int w = 0; w < WORDS; w++) begin
         if (bus_addr == ADDR_W'(DATA_OFS + 4 * w)) bus_rdata = words[w];
      end
   end

   // R1: a write with an empty mask leaves the stored control bits alone
   p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && mask == '0) |=> $stable(ctl_q));

   // R10: writes elsewhere never touch the control bits
   p_ro_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !ctl_wr) |=> $stable(ctl_q));
endmodule

// File: tb/trng_sampler_bench.sv
`timescale 1ns/1ps
module trng_sampler_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = 12'h400;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   always #4 clk = ~clk;

   trng_sampler u_trng_sampler (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   bit finished = 0;
   string tag = "R11";

   // behavioural reference state
   logic [15:1]  m_ctl;
   bit           m_run;
   logic [31:0]  m_per;
   longint       m_cnt;
   int           m_nb;
   logic [255:0] m_data;
   logic [31:0]  m_lfsr;
   logic [15:0]  cur, nc, msk;
   bit           cw, sr, spr;
   longint       eff;

   function automatic logic [31:0] expected(input logic [11:0] a);
      if (a == 12'h400) return {16'h0, m_ctl, m_run};
      if (a == 12'h404) return m_per;
      for (int w = 0; w < 8; w++)
         if (a == 12'h410 + 12'(4 * w)) return m_data[w*32 +: 32];
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = '0; m_run = 0; m_per = 1000; m_cnt = 0; m_nb = 0;
         m_data = '0; m_lfsr = 32'hACE1_2357;
      end else begin
         cw  = bus_wr && bus_addr == 12'h400;
         msk = bus_wdata[31:16];
         cur = {m_ctl, m_run};
         nc  = (cur & ~msk) | (bus_wdata[15:0] & msk);
         sr  = cw && msk[0] && bus_wdata[0] && nc[1];
         spr = cw && !sr && (!nc[1] || (msk[0] && !bus_wdata[0]));
         if (sr) begin
            m_run = 1; m_cnt = 0; m_nb = 0; m_data = '0;
         end else if (spr) begin
            m_run = 0;
         end else if (m_run && m_ctl[1]) begin
            eff = (m_per == 0) ? 1 : longint'(m_per);
            if (m_cnt + 1 >= eff) begin
               m_data[m_nb] = m_lfsr[0];
               m_nb++;
               m_cnt = 0;
               if (m_nb >= (int'(m_ctl[5:4]) + 1) * 64) m_run = 0;
            end else m_cnt++;
         end
         if (cw) m_ctl = nc[15:1];
         if (bus_wr && bus_addr == 12'h404) m_per = bus_wdata;
         m_lfsr = {1'b0, m_lfsr[31:1]} ^ (m_lfsr[0] ? 32'h8020_0003 : 32'h0);
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         compared++;
         if (bus_rdata !== expected(bus_addr)) begin
            mismatched++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, bus_addr, bus_rdata, expected(bus_addr));
         end
      end
   end

   task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", t, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0; bus_addr = 12'h400;
   endtask

   task automatic rd_chk(input string t, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      check(t, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_words();
      for (int w = 0; w < 8; w++) begin
         @(negedge clk); #1;
         bus_addr = 12'h410 + 12'(4 * w);
      end
      @(negedge clk); #1;
      bus_addr = 12'h400;
   endtask

   task automatic wait_done(input string t);
      bit seen = 0;
      @(negedge clk); #1;
      bus_addr = 12'h400;
      for (int i = 0; i < 4000 && !seen; i++) begin
         @(negedge clk);
         if (bus_rdata[0] == 1'b0) seen = 1;
      end
      check(t, {31'h0, seen}, 32'h1);
   endtask

   task automatic run_case(input logic [31:0] per, input int len);
      tag = "R3 R4 R5 R8";
      wr(12'h404, per);
      wr(12'h400, 32'h0030_0000 | (32'(len) << 4));
      wr(12'h400, 32'h0001_0001);
      wait_done("R4 start self-clears");
      tag = "R5 R6 R8 data words";
      read_words();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1;
         mismatched++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      // R11 reset state
      rd_chk("R11 control reset", 12'h400, 32'h0);
      rd_chk("R11 period reset", 12'h404, 32'd1000);
      read_words();

      // R1 masked control writes
      tag = "R1";
      wr(12'h400, 32'hFFFF_0016);
      rd_chk("R1 full mask", 12'h400, 32'h0016);
      wr(12'h400, 32'h0002_0000);
      rd_chk("R1 single-bit mask", 12'h400, 32'h0014);
      wr(12'h400, 32'h0000_FFFF);
      rd_chk("R1 empty mask", 12'h400, 32'h0014);

      // R2 start without enable
      tag = "R2";
      wr(12'h400, 32'h0001_0001);
      rd_chk("R2 start ignored", 12'h400, 32'h0014);

      // enable, then runs of each length and several periods
      wr(12'h400, 32'hFFFF_0002);
      tag = "R3";
      wr(12'h404, 32'd3);
      wr(12'h400, 32'h0001_0001);
      rd_chk("R3 start reads one", 12'h400, 32'h0003);
      wait_done("R4 64-bit run ends");
      read_words();
      run_case(32'd1, 3);
      run_case(32'd2, 1);
      run_case(32'd4, 2);
      run_case(32'd0, 0);

      // R7 stop in the middle of a run
      tag = "R7";
      wr(12'h404, 32'd2);
      wr(12'h400, 32'h0030_0030);
      wr(12'h400, 32'h0001_0001);
      idle(40);
      wr(12'h400, 32'hFFFF_0000);
      rd_chk("R7 stop clears control", 12'h400, 32'h0);
      read_words();

      // R2 clearing enable mid-run stops it
      wr(12'h400, 32'hFFFF_0002);
      wr(12'h400, 32'h0001_0001);
      idle(10);
      tag = "R2";
      wr(12'h400, 32'h0002_0000);
      rd_chk("R2 enable drop stops run", 12'h400, 32'h0000);
      wr(12'h400, 32'h0002_0002);

      // R9 restart mid-run and on the completing edge
      tag = "R9";
      wr(12'h404, 32'd1);
      wr(12'h400, 32'h0030_0000);
      wr(12'h400, 32'h0001_0001);
      idle(10);
      wr(12'h400, 32'h0001_0001);
      wait_done("R9 restart mid-run completes");
      read_words();
      wr(12'h400, 32'h0001_0001);
      idle(62);
      wr(12'h400, 32'h0001_0001);
      rd_chk("R9 restart wins over completion", 12'h400, 32'h0003);
      wait_done("R9 restarted run completes");
      read_words();

      // R10 writes to read-only and unmapped offsets
      tag = "R10";
      wr(12'h410, 32'hFFFF_FFFF);
      wr(12'h41C, 32'h1234_5678);
      wr(12'h408, 32'hFFFF_FFFF);
      rd_chk("R10 unmapped read", 12'h408, 32'h0);
      rd_chk("R10 unaligned read", 12'h402, 32'h0);
      read_words();

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule